// File: doc/BRIEF.md
# Two-Step Converter Timing Sequencer

This block is the digital control core of an 8-bit two-step converter. The converter resolves the upper nibble with a coarse comparator bank and the lower nibble with a fine comparator bank. The sequencer watches a chip-select, a read strobe, a write strobe and a mode strap. It drives the compare/zero phase of each bank and counts the ones in each 15-bit thermometer word to get a nibble. It captures the two nibbles and the over-range flag, then reports the finished word through an interrupt flag, a ready flag and an output-enable for the 8-bit result latch. Every analog delay is a count of system clock cycles set by a parameter.

The strap selects one of two handshakes.

- **Strap low (self-timed read handshake):** a read strobe alone starts the conversion. The sequencer then steps through both phases on its own timer.
- **Strap high (write-then-read handshake):** the write strobe frames the sampling window. The result lands either when the internal timeout expires or on an early read edge, whichever comes first.

After every result, the coarse bank gets a guaranteed zeroing window. A start request that arrives inside this window is kept and carried out when the window closes.

Top module: `hf_adc_sequencer`

## Requirements
- R1: While cs_n is high, edges on rd_n and wr_n start nothing. coarse_cmp stays 0, int_n does not fall, and rdy_low is not set.
- R2: With mode_wr=1, a falling wr_n (cs_n low) sets coarse_cmp=1 and fine_cmp=0 from the next clock. The first clock with wr_n high captures the coarse nibble (the upper half of the result), clears coarse_cmp and sets fine_cmp. A coarse_therm change after that clock has no effect on the result.
- R3: With mode_wr=1 and no read, the result is loaded into data_q exactly T_PHASE clocks after the clock that captured the coarse nibble. int_n falls at that same clock.
- R4: With mode_wr=1, a falling rd_n (cs_n low) while the fine bank compares loads the result on the next clock and drives int_n low. The timeout is not awaited.
- R5: With mode_wr=0, a falling rd_n (cs_n low) starts the conversion. Coarse compare lasts T_PHASE clocks and is followed by fine compare for T_PHASE clocks. The result loads 2*T_PHASE clocks after the start clock. The coarse nibble is captured when fine compare begins.
- R6: With mode_wr=0, rdy_low rises one clock after cs_n falls and returns to 0 on the clock the result loads. With mode_wr=1, rdy_low is never set.
- R7: A rising rd_n, a rising cs_n, or an accepted new start each return int_n to 1.
- R8: data_oe is 1 only when cs_n and rd_n were both low on the previous clock. With mode_wr=0 it also requires that no conversion is in progress or pending.
- R9: ofl_n takes the inverse of the over-range comparator, as it was at the coarse capture. It changes only on the clock that loads a result.
- R10: After each result, coarse_cmp and fine_cmp both stay 0 for at least T_RECOVER clocks.
- R11: A start request accepted during the recovery window is held. It begins on the first clock after the window, so coarse_cmp rises exactly T_RECOVER clocks after the result clock.
- R12: Each thermometer word becomes a nibble equal to its count of ones. data_q = {coarse nibble, fine nibble}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Strap: 1 = write-then-read handshake, 0 = self-timed read handshake |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| coarse_therm | input | 15 | Coarse comparator bank, thermometer code |
| over_range | input | 1 | Over-range comparator of the coarse bank |
| fine_therm | input | 15 | Fine comparator bank, thermometer code |
| coarse_cmp | output | 1 | Coarse bank phase: 1 = compare, 0 = zero |
| fine_cmp | output | 1 | Fine bank phase: 1 = compare, 0 = zero |
| data_q | output | 8 | Result latch contents |
| data_oe | output | 1 | Enable for the tri-state data drivers |
| ofl_n | output | 1 | Overflow flag, active low, always driven |
| int_n | output | 1 | Conversion-done flag, active low |
| rdy_low | output | 1 | 1 = pull the ready line low, 0 = release it |

## Verification
A wrong state in the phase machine shows up within one clock on the two phase outputs. Examples are a bank left comparing, both banks comparing at once, or a recovery window cut short. A counting or capture error appears as a wrong word on data_q at the very clock int_n falls. A scoreboard compares that word with the value worked out from the thermometer stimulus. Timer faults shift the int_n edge by whole clocks, so the bench samples the clock before and the clock of each expected edge. Handshake faults in rdy_low and data_oe become visible one clock after the strobe that should move them.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

  localparam int NIB_W   = 4;
  localparam int THERM_W = (1 << NIB_W) - 1;
  localparam int WORD_W  = 2 * NIB_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_HOLD,
    ST_WR_FINE,
    ST_RD_COARSE,
    ST_RD_FINE,
    ST_RECOVER
  } seq_state_t;

  // Level of a thermometer word: number of comparators that tripped.
  function automatic logic [NIB_W-1:0] therm_level(input logic [THERM_W-1:0] t);
    logic [NIB_W-1:0] n;
    n = '0;
    for (int i = 0; i < THERM_W; i++) n = n + NIB_W'(t[i]);
    return n;
  endfunction

endpackage

// File: rtl/hfs_strobe_edges.sv
module hfs_strobe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic cs_q,
  output logic rd_q,
  output logic cs_fall,
  output logic cs_rise,
  output logic rd_fall_sel,
  output logic rd_rise,
  output logic wr_fall_sel
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      cs_q <= cs_n;
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end

  assign cs_fall     = cs_q & ~cs_n;
  assign cs_rise     = ~cs_q & cs_n;
  assign rd_rise     = ~rd_q & rd_n;
  // strobe falls only count while selected
  assign rd_fall_sel = rd_q & ~rd_n & ~cs_n;
  assign wr_fall_sel = wr_q & ~wr_n & ~cs_n;
endmodule

// File: rtl/hfs_therm_enc.sv
module hfs_therm_enc
  import hfs_pkg::*;
(
  input  logic [THERM_W-1:0] therm,
  output logic [NIB_W-1:0]   level
);
  assign level = therm_level(therm);
endmodule

// File: rtl/hfs_phase_timer.sv
module hfs_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/hf_adc_sequencer.sv
module hf_adc_sequencer
  import hfs_pkg::*;
#(
  parameter int T_PHASE   = 40,
  parameter int T_RECOVER = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [THERM_W-1:0] coarse_therm,
  input  logic               over_range,
  input  logic [THERM_W-1:0] fine_therm,
  output logic               coarse_cmp,
  output logic               fine_cmp,
  output logic [WORD_W-1:0]  data_q,
  output logic               data_oe,
  output logic               ofl_n,
  output logic               int_n,
  output logic               rdy_low
);
  localparam int T_MAX = (T_PHASE > T_RECOVER) ? T_PHASE : T_RECOVER;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] PH_M1 = CNT_W'(T_PHASE - 1);
  localparam logic [CNT_W-1:0] RC_M1 = CNT_W'(T_RECOVER - 1);

  // strobe events
  logic cs_q, rd_q, cs_fall, cs_rise, rd_fall_sel, rd_rise, wr_fall_sel;

  hfs_strobe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cs_q(cs_q), .rd_q(rd_q), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .rd_fall_sel(rd_fall_sel), .rd_rise(rd_rise), .wr_fall_sel(wr_fall_sel)
  );

  // comparator bank encoders: index 1 = coarse, 0 = fine
  logic [1:0][THERM_W-1:0] bank_therm;
  logic [1:0][NIB_W-1:0]   bank_level;
  assign bank_therm[1] = coarse_therm;
  assign bank_therm[0] = fine_therm;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    hfs_therm_enc u_enc (.therm(bank_therm[g]), .level(bank_level[g]));
  end

  // phase timer
  logic             t_load, t_exp;
  logic [CNT_W-1:0] t_val;

  hfs_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  // sequencer state
  seq_state_t       st, st_d;
  logic             pend, pend_d;
  logic [NIB_W-1:0] hi_nib;
  logic             ovr_hold;

  // named internal events
  logic start_req, start_ok, start_go, lat_hi, lat_res, clr_int, rd_busy;
  seq_state_t start_st;

  assign start_req = mode_wr ? wr_fall_sel : rd_fall_sel;
  assign start_ok  = start_req && (st == ST_IDLE || st == ST_RECOVER);
  assign start_st  = mode_wr ? ST_WR_HOLD : ST_RD_COARSE;

  always_comb begin
    st_d     = st;
    pend_d   = pend;
    t_load   = 1'b0;
    t_val    = PH_M1;
    lat_hi   = 1'b0;
    lat_res  = 1'b0;
    start_go = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start_req) start_go = 1'b1;
      end
      ST_WR_HOLD: begin
        if (wr_n) begin
          st_d   = ST_WR_FINE;
          lat_hi = 1'b1;
          t_load = 1'b1;
        end
      end
      ST_WR_FINE: begin
        if (rd_fall_sel || t_exp) lat_res = 1'b1;
      end
      ST_RD_COARSE: begin
        if (t_exp) begin
          st_d   = ST_RD_FINE;
          lat_hi = 1'b1;
          t_load = 1'b1;
        end
      end
      ST_RD_FINE: begin
        if (t_exp) lat_res = 1'b1;
      end
      ST_RECOVER: begin
        if (start_req) pend_d = 1'b1;
        if (t_exp) begin
          if (pend || start_req) start_go = 1'b1;
          else                   st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (start_go) begin
      st_d   = start_st;
      pend_d = 1'b0;
      t_load = 1'b1;
      t_val  = PH_M1;
    end
    if (lat_res) begin
      st_d   = ST_RECOVER;
      t_load = 1'b1;
      t_val  = RC_M1;
    end
  end

  assign clr_int = rd_rise | cs_rise | start_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pend     <= 1'b0;
      hi_nib   <= '0;
      ovr_hold <= 1'b0;
      data_q   <= '0;
      ofl_n    <= 1'b1;
      int_n    <= 1'b1;
      rdy_low  <= 1'b0;
    end else begin
      st   <= st_d;
      pend <= pend_d;
      if (lat_hi) begin
        hi_nib   <= bank_level[1];
        ovr_hold <= over_range;
      end
      if (lat_res) begin
        data_q <= {hi_nib, bank_level[0]};
        ofl_n  <= ~ovr_hold;
      end
      if (lat_res)      int_n <= 1'b0;
      else if (clr_int) int_n <= 1'b1;
      if (lat_res)                 rdy_low <= 1'b0;
      else if (cs_fall && !mode_wr) rdy_low <= 1'b1;
    end
  end

  assign coarse_cmp = (st == ST_WR_HOLD) || (st == ST_RD_COARSE);
  assign fine_cmp   = (st == ST_WR_FINE) || (st == ST_RD_FINE);
  assign rd_busy    = (st == ST_RD_COARSE) || (st == ST_RD_FINE) || pend;
  assign data_oe    = ~cs_q & ~rd_q & (mode_wr | ~rd_busy);

endmodule

// File: rtl/hfs_seq_chk.sv
module hfs_seq_chk #(
  parameter int T_RECOVER = 25
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rd_n,
  input logic coarse_cmp,
  input logic fine_cmp,
  input logic data_oe,
  input logic ofl_n,
  input logic int_n,
  input logic rdy_low
);
  localparam int GW = $clog2(T_RECOVER + 1);
  logic [GW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        idle_cnt <= GW'(T_RECOVER);
    else if (coarse_cmp || fine_cmp)   idle_cnt <= '0;
    else if (idle_cnt != GW'(T_RECOVER)) idle_cnt <= idle_cnt + 1'b1;
  end

  // R2
  phases_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(coarse_cmp && fine_cmp));

  // R8
  oe_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!$past(cs_n) && !$past(rd_n)));

  // R3
  int_after_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(fine_cmp));

  // R9
  ofl_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ofl_n) |-> $fell(int_n));

  // R10
  recover_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coarse_cmp) |-> (int'(idle_cnt) >= T_RECOVER));

  // R6
  rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_low) |-> $fell(int_n));
endmodule

bind hf_adc_sequencer hfs_seq_chk #(.T_RECOVER(T_RECOVER)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
  .coarse_cmp(coarse_cmp), .fine_cmp(fine_cmp), .data_oe(data_oe),
  .ofl_n(ofl_n), .int_n(int_n), .rdy_low(rdy_low)
);

// File: tb/hf_adc_sequencer_bench.sv
module hf_adc_sequencer_bench;
  localparam int T_PH = 40;
  localparam int T_RC = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, over_range = 1'b0;
  logic [14:0] coarse_therm = '0, fine_therm = '0;
  logic coarse_cmp, fine_cmp, data_oe, ofl_n, int_n, rdy_low;
  logic [7:0] data_q;

  hf_adc_sequencer #(.T_PHASE(T_PH), .T_RECOVER(T_RC)) u_hf_adc_sequencer (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .coarse_therm(coarse_therm), .over_range(over_range),
    .fine_therm(fine_therm), .coarse_cmp(coarse_cmp), .fine_cmp(fine_cmp),
    .data_q(data_q), .data_oe(data_oe), .ofl_n(ofl_n), .int_n(int_n),
    .rdy_low(rdy_low)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];
  logic [8:0] exp_item;
  logic int_prev = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [14:0] th(input int n);
    return 15'((16'(1) << n) - 16'(1));
  endfunction

  // expected word: {ofl_n, coarse ones, fine ones}
  task automatic push_exp(input bit ovr, input int hi, input int lo);
    exp_q.push_back({~ovr, 4'(hi), 4'(lo)});
  endtask

  // scoreboard monitor: every falling int_n delivers one result
  always @(negedge clk) begin
    if (rst_n) begin
      if (int_prev && !int_n) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected result", int'(data_q), 0);
        else begin
          exp_item = exp_q.pop_front();
          chk({ofl_n, data_q} == exp_item, "R12 result word", int'({ofl_n, data_q}), int'(exp_item));
        end
      end
      int_prev = int_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(int_n == 1'b1 && ofl_n == 1'b1, "reset flags", int'({int_n, ofl_n}), 3);
    chk(!coarse_cmp && !fine_cmp && !data_oe && !rdy_low && data_q == 8'h00, "reset outputs",
        int'({coarse_cmp, fine_cmp, data_oe, rdy_low, data_q}), 0);

    // R1: strobes with cs high do nothing
    wr_n = 1'b0; tick(3);
    chk(!coarse_cmp, "R1 wr ignored", coarse_cmp, 0);
    wr_n = 1'b1; mode_wr = 1'b0; rd_n = 1'b0; tick(3);
    chk(!coarse_cmp && int_n && !rdy_low, "R1 rd ignored", int'({coarse_cmp, int_n, rdy_low}), 2);
    rd_n = 1'b1; mode_wr = 1'b1; tick(2);

    // R2, R3: write-then-read with timeout
    coarse_therm = th(9); fine_therm = th(5); over_range = 1'b0;
    cs_n = 1'b0; wr_n = 1'b0; tick(1);
    chk(coarse_cmp && !fine_cmp, "R2 coarse compare on wr fall", int'({coarse_cmp, fine_cmp}), 2);
    chk(!rdy_low, "R6 no ready in write mode", rdy_low, 0);
    tick(5);
    wr_n = 1'b1; tick(1);
    chk(!coarse_cmp && fine_cmp, "R2 fine compare after wr rise", int'({coarse_cmp, fine_cmp}), 1);
    coarse_therm = th(2);
    push_exp(1'b0, 9, 5);
    tick(T_PH - 1);
    chk(int_n, "R3 int before timeout", int_n, 1);
    tick(1);
    chk(!int_n, "R3 int at timeout", int_n, 0);
    cs_n = 1'b1; tick(1);
    chk(int_n, "R7 cs rise clears int", int_n, 1);
    tick(T_RC);

    // R4: early read cuts the timeout short
    coarse_therm = th(15); fine_therm = th(0); over_range = 1'b1;
    cs_n = 1'b0; wr_n = 1'b0; tick(3);
    wr_n = 1'b1; tick(1);
    tick(4);
    chk(int_n, "R4 int before early read", int_n, 1);
    rd_n = 1'b0; push_exp(1'b1, 15, 0); tick(1);
    chk(!int_n && !fine_cmp, "R4 early read latches", int'({int_n, fine_cmp}), 0);
    chk(data_oe, "R8 oe with cs and rd low", data_oe, 1);
    chk(!ofl_n, "R9 overflow flagged", ofl_n, 0);
    rd_n = 1'b1; tick(1);
    chk(int_n && !data_oe, "R7 rd rise clears int", int'({int_n, data_oe}), 2);

    // R10, R11: start during recovery is held
    wr_n = 1'b0; tick(1);
    chk(!coarse_cmp, "R10 start deferred", coarse_cmp, 0);
    wr_n = 1'b1; coarse_therm = th(3); fine_therm = th(12); over_range = 1'b0;
    push_exp(1'b0, 3, 12);
    tick(T_RC - 3);
    chk(!coarse_cmp, "R10 still zeroing at window end", coarse_cmp, 0);
    tick(1);
    chk(coarse_cmp, "R11 pending start begins", coarse_cmp, 1);
    tick(1);
    chk(fine_cmp, "R11 pending write completes capture", fine_cmp, 1);
    tick(T_PH);
    chk(!int_n && ofl_n, "R11 pending result", int'({int_n, ofl_n}), 1);

    // R5, R6, R8, R9: self-timed read handshake
    mode_wr = 1'b0; cs_n = 1'b1; tick(1);
    chk(int_n, "R7 cs rise clears int", int_n, 1);
    tick(T_RC);
    cs_n = 1'b0; tick(1);
    chk(rdy_low, "R6 ready pulled after cs fall", rdy_low, 1);
    coarse_therm = th(7); fine_therm = th(10); over_range = 1'b1;
    rd_n = 1'b0; push_exp(1'b1, 7, 10); tick(1);
    chk(coarse_cmp && !data_oe, "R5 read starts coarse, R8 oe held", int'({coarse_cmp, data_oe}), 2);
    tick(T_PH - 1);
    chk(coarse_cmp && !fine_cmp, "R5 coarse phase length", int'({coarse_cmp, fine_cmp}), 2);
    tick(1);
    chk(!coarse_cmp && fine_cmp, "R5 fine phase begins", int'({coarse_cmp, fine_cmp}), 1);
    coarse_therm = th(1);
    tick(T_PH - 1);
    chk(int_n && rdy_low && !data_oe, "R5 not done yet", int'({int_n, rdy_low, data_oe}), 6);
    tick(1);
    chk(!int_n && !rdy_low, "R6 ready released at result", int'({int_n, rdy_low}), 0);
    chk(data_oe && !ofl_n, "R8 oe after finish, R9 ofl", int'({data_oe, ofl_n}), 2);
    rd_n = 1'b1; tick(1);
    chk(int_n && !data_oe, "R7 rd rise clears int", int'({int_n, data_oe}), 2);

    // R8, R11: pending read keeps outputs off
    coarse_therm = th(0); fine_therm = th(15); over_range = 1'b0;
    rd_n = 1'b0; push_exp(1'b0, 0, 15); tick(1);
    chk(!data_oe && !coarse_cmp, "R8 oe off while read pending", int'({data_oe, coarse_cmp}), 0);
    tick(T_RC - 2);
    chk(coarse_cmp, "R11 pending read begins", coarse_cmp, 1);
    tick(2 * T_PH);
    chk(!int_n && ofl_n, "R9 ofl released", int'({int_n, ofl_n}), 1);
    rd_n = 1'b1; tick(1);
    tick(T_RC);

    // R7: stand-alone write mode, new start clears int
    mode_wr = 1'b1; rd_n = 1'b0; tick(2);
    chk(!coarse_cmp, "R1 read ignored in write mode", coarse_cmp, 0);
    coarse_therm = th(6); fine_therm = th(6);
    push_exp(1'b0, 6, 6);
    wr_n = 1'b0; tick(2);
    wr_n = 1'b1; tick(1);
    tick(T_PH);
    chk(!int_n && data_oe, "R3 stand-alone result", int'({int_n, data_oe}), 1);
    tick(T_RC);
    coarse_therm = th(1); fine_therm = th(2);
    push_exp(1'b0, 1, 2);
    wr_n = 1'b0; tick(1);
    chk(int_n && coarse_cmp, "R7 start clears int", int'({int_n, coarse_cmp}), 3);
    wr_n = 1'b1; tick(1);
    tick(T_PH);
    chk(!int_n, "R12 second stand-alone result", int_n, 0);
    tick(2);
    chk(exp_q.size() == 0, "R12 all results seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule